// File: doc/BRIEF.md
# ECP Link Phase Sequencer

This block sits on the host side of an IEEE 1284 parallel link that is running in ECP mode. It drives the host control lines and the data-bus direction through the ordered handshake events that carry the link between its phases. Three operations are available. Setup takes the link from a finished negotiation into forward idle. Go-reverse hands the data bus to the peripheral and ends in reverse idle. Go-forward takes the bus back and ends in forward idle. Each operation is started by a one-cycle command strobe.

A phase register records where the link stands, and a command that does not fit the current phase is refused with a link error. Every wait on the peripheral status lines has a cycle-counted timeout. The status lines are synchronised before any comparison. The current handshake event number is available on an output, so that software or a debugger can see where a sequence stopped. Each sequence ends with a one-cycle done pulse, and the error code stays valid until the next command is accepted.

Top module: `ecp_phase_seq`

## Requirements
- R1: After reset the block drives the following: `out_strb`=1, `out_hack`=1, `out_rreq`=1, `out_sel`=1, `out_dir_in`=0, `out_phase`=0 (unknown), `out_event`=0, `out_err`=0 (none), `out_done`=0 and `out_rd_avail`=0.
- R2: When `cmd_setup` is accepted, the next clock edge sets `out_sel`=1, `out_rreq`=1, `out_hack`=0, `out_strb`=1 and `out_dir_in`=0. The same edge sets `out_phase`=1 (setup) and `out_event`=30, and clears `out_err` to 0.
- R3: The setup wait is met when the synchronised status shows `in_pack`=0, `in_pclk`=1, `in_arev`=1 and `in_xflag`=1. The value of `in_preq` has no effect. When the wait is met, `out_phase` becomes 2 (forward idle), `out_event` becomes 31, `out_err` stays 0 and `out_done` pulses.
- R4: If the setup wait is not met within TIMEOUT_CYC evaluated cycles, `out_phase` becomes 0 and `out_err` becomes 1 (device error), and `out_done` pulses.
- R5: `cmd_reverse` outside phase 2, or `cmd_forward` outside phase 4, produces `out_err`=2 (link failure) and a done pulse on the next edge. The phase and all control lines stay unchanged.
- R6: When go-reverse is accepted, `out_phase` becomes 3 and `out_dir_in` becomes 1 on the first edge. `out_hack` is driven 0 with `out_event`=38 on the following edge.
- R7: `out_rreq` falls, with `out_event`=39, exactly HOLD_CYC cycles after event 38. HOLD_CYC = ceil(HOLD_NS*CLK_HZ/1e9), with a minimum of 1.
- R8: After event 39, synchronised `in_arev`=0 gives `out_phase`=4 (reverse idle) and `out_event`=40. If the timeout expires first, the result is `out_err`=2 and `out_phase`=0.
- R9: When go-forward is accepted, the first edge sets `out_phase`=5 and `out_hack`=1. The next edge sets `out_rreq`=1 and `out_event`=47.
- R10: Event 48 needs `in_pack`=0 and `in_pclk`=1. After it, event 49 additionally needs `in_arev`=1 and `in_xflag`=1. Success at event 49 returns `out_dir_in` to 0 and sets `out_phase`=2. A timeout in either wait gives `out_err`=2 and `out_phase`=0.
- R11: `out_rd_avail` equals the inverse of `in_preq`, delayed by two clock edges.
- R12: Commands that arrive while a sequence runs are ignored. Simultaneous commands are ranked setup first, then reverse, then forward. `out_done` lasts one cycle, and `out_err` holds until the next accepted command.
- R13: The timeout is TIMEOUT_CYC = ceil(TIMEOUT_NS*CLK_HZ/1e9) evaluated cycles. If a condition is met on the last counted cycle, the result is success and not a timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_setup | input | 1 | Strobe: run the setup phase |
| cmd_reverse | input | 1 | Strobe: turn the link to reverse |
| cmd_forward | input | 1 | Strobe: turn the link back to forward |
| in_pack | input | 1 | Peripheral acknowledge/busy status line |
| in_pclk | input | 1 | Peripheral clock status line |
| in_arev | input | 1 | Active-low reverse acknowledge status line |
| in_xflag | input | 1 | Extensibility flag status line |
| in_preq | input | 1 | Active-low peripheral request status line |
| out_strb | output | 1 | Host strobe line level |
| out_hack | output | 1 | Host acknowledge line level |
| out_rreq | output | 1 | Active-low reverse request line level |
| out_sel | output | 1 | Active-low select line level |
| out_dir_in | output | 1 | 1 = data bus is input to the host |
| out_phase | output | 3 | Phase code (0 unknown, 1 setup, 2 fwd idle, 3 fwd-to-rev, 4 rev idle, 5 rev-to-fwd) |
| out_event | output | 6 | Last handshake event reached |
| out_done | output | 1 | One-cycle end-of-sequence pulse |
| out_err | output | 2 | Result code (0 none, 1 device, 2 link) |
| out_rd_avail | output | 1 | Peripheral has read data ready |

## Verification
A status wait can be satisfied on the same cycle in which its timeout counter reaches its limit. The bench provokes this by releasing `in_xflag` during a setup wait, timed so that the synchronised value first arrives on the final counted cycle. That run must end as forward idle with no error. The same release one cycle later must end with a device error, and both outcomes are judged at the exact cycle of the done pulse.

// File: rtl/ecp_seq_pkg.sv
package ecp_seq_pkg;

  typedef enum logic [2:0] {
    PH_UNKNOWN    = 3'd0,
    PH_SETUP      = 3'd1,
    PH_FWD_IDLE   = 3'd2,
    PH_FWD_TO_REV = 3'd3,
    PH_REV_IDLE   = 3'd4,
    PH_REV_TO_FWD = 3'd5
  } phase_e;

  typedef enum logic [1:0] {
    ER_NONE   = 2'd0,
    ER_DEVICE = 2'd1,
    ER_LINK   = 2'd2
  } err_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_W31, ST_REV_ACK, ST_REV_HOLD, ST_W40,
    ST_FWD_RREQ, ST_W48, ST_W49
  } st_e;

  typedef struct packed {
    logic pack;
    logic pclk;
    logic arev;
    logic xflag;
    logic preq;
  } stat_t;

  // Nanoseconds to whole clock cycles, rounded up, never below one.
  function automatic int unsigned ns_to_cycles(int unsigned ns, int unsigned hz);
    longint unsigned p;
    p = (64'(ns) * 64'(hz) + 64'd999_999_999) / 64'd1_000_000_000;
    if (p == 64'd0) p = 64'd1;
    return 32'(p);
  endfunction

  function automatic logic met_fwd_ready(stat_t s);
    return !s.pack && s.pclk && s.arev && s.xflag;
  endfunction

  function automatic logic met_rev_ack(stat_t s);
    return !s.arev;
  endfunction

  function automatic logic met_pre_turn(stat_t s);
    return !s.pack && s.pclk;
  endfunction

endpackage

// File: rtl/ecp_sync2.sv
module ecp_sync2 #(
  parameter int W = 5,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [1:0] ff;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ff <= {2{RST_VAL[i]}};
      else        ff <= {ff[0], d[i]};
    end
    assign q[i] = ff[1];
  end
endmodule

// File: rtl/ecp_interval.sv
module ecp_interval #(
  parameter int unsigned LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic hit
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt;

  assign hit = run && (cnt == CW'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (clr)        cnt <= '0;
    else if (run && !hit) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/ecp_phase_seq.sv
module ecp_phase_seq
  import ecp_seq_pkg::*;
#(
  parameter int unsigned CLK_HZ     = 250_000_000,
  parameter int unsigned HOLD_NS    = 500,
  parameter int unsigned TIMEOUT_NS = 35_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_setup,
  input  logic       cmd_reverse,
  input  logic       cmd_forward,
  input  logic       in_pack,
  input  logic       in_pclk,
  input  logic       in_arev,
  input  logic       in_xflag,
  input  logic       in_preq,
  output logic       out_strb,
  output logic       out_hack,
  output logic       out_rreq,
  output logic       out_sel,
  output logic       out_dir_in,
  output logic [2:0] out_phase,
  output logic [5:0] out_event,
  output logic       out_done,
  output logic [1:0] out_err,
  output logic       out_rd_avail
);
  localparam int unsigned HOLD_CYC    = ns_to_cycles(HOLD_NS, CLK_HZ);
  localparam int unsigned TIMEOUT_CYC = ns_to_cycles(TIMEOUT_NS, CLK_HZ);

  st_e    st;
  phase_e phase_q;
  err_e   err_q;
  stat_t  raw, syn;

  assign raw = '{pack: in_pack, pclk: in_pclk, arev: in_arev,
                 xflag: in_xflag, preq: in_preq};

  ecp_sync2 #(.W($bits(stat_t)), .RST_VAL('1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(syn)
  );

  // Named internal events.
  logic idle, go_setup, go_rev, go_fwd, rej_pulse;
  logic in_wait, cond_met, step48, wait_clr, wait_hit, hold_hit;

  assign idle     = (st == ST_IDLE);
  assign go_setup = idle && cmd_setup;
  assign go_rev   = idle && !cmd_setup && cmd_reverse;
  assign go_fwd   = idle && !cmd_setup && !cmd_reverse && cmd_forward;
  assign rej_pulse = (go_rev && phase_q != PH_FWD_IDLE) ||
                     (go_fwd && phase_q != PH_REV_IDLE);

  always_comb begin
    in_wait  = 1'b1;
    cond_met = 1'b0;
    unique case (st)
      ST_W31:  cond_met = met_fwd_ready(syn);
      ST_W40:  cond_met = met_rev_ack(syn);
      ST_W48:  cond_met = met_pre_turn(syn);
      ST_W49:  cond_met = met_fwd_ready(syn);
      default: in_wait  = 1'b0;
    endcase
  end

  assign step48   = (st == ST_W48) && cond_met;
  assign wait_clr = !in_wait || step48;

  ecp_interval #(.LIMIT(TIMEOUT_CYC)) u_timeout (
    .clk(clk), .rst_n(rst_n), .clr(wait_clr), .run(in_wait), .hit(wait_hit)
  );

  ecp_interval #(.LIMIT(HOLD_CYC)) u_hold (
    .clk(clk), .rst_n(rst_n), .clr(st != ST_REV_HOLD),
    .run(st == ST_REV_HOLD), .hit(hold_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      phase_q    <= PH_UNKNOWN;
      err_q      <= ER_NONE;
      out_done   <= 1'b0;
      out_event  <= 6'd0;
      out_strb   <= 1'b1;
      out_hack   <= 1'b1;
      out_rreq   <= 1'b1;
      out_sel    <= 1'b1;
      out_dir_in <= 1'b0;
    end else begin
      out_done <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (go_setup) begin
            phase_q    <= PH_SETUP;
            err_q      <= ER_NONE;
            out_sel    <= 1'b1;
            out_rreq   <= 1'b1;
            out_hack   <= 1'b0;
            out_strb   <= 1'b1;
            out_dir_in <= 1'b0;
            out_event  <= 6'd30;
            st         <= ST_W31;
          end else if (rej_pulse) begin
            err_q    <= ER_LINK;
            out_done <= 1'b1;
          end else if (go_rev) begin
            phase_q    <= PH_FWD_TO_REV;
            err_q      <= ER_NONE;
            out_dir_in <= 1'b1;
            st         <= ST_REV_ACK;
          end else if (go_fwd) begin
            phase_q  <= PH_REV_TO_FWD;
            err_q    <= ER_NONE;
            out_hack <= 1'b1;
            st       <= ST_FWD_RREQ;
          end
        end
        ST_W31: begin
          if (cond_met) begin
            phase_q   <= PH_FWD_IDLE;
            out_event <= 6'd31;
            out_done  <= 1'b1;
            st        <= ST_IDLE;
          end else if (wait_hit) begin
            phase_q  <= PH_UNKNOWN;
            err_q    <= ER_DEVICE;
            out_done <= 1'b1;
            st       <= ST_IDLE;
          end
        end
        ST_REV_ACK: begin
          out_hack  <= 1'b0;
          out_event <= 6'd38;
          st        <= ST_REV_HOLD;
        end
        ST_REV_HOLD: begin
          if (hold_hit) begin
            out_rreq  <= 1'b0;
            out_event <= 6'd39;
            st        <= ST_W40;
          end
        end
        ST_W40: begin
          if (cond_met) begin
            phase_q   <= PH_REV_IDLE;
            out_event <= 6'd40;
            out_done  <= 1'b1;
            st        <= ST_IDLE;
          end else if (wait_hit) begin
            phase_q  <= PH_UNKNOWN;
            err_q    <= ER_LINK;
            out_done <= 1'b1;
            st       <= ST_IDLE;
          end
        end
        ST_FWD_RREQ: begin
          out_rreq  <= 1'b1;
          out_event <= 6'd47;
          st        <= ST_W48;
        end
        ST_W48, ST_W49: begin
          if (cond_met && st == ST_W48) begin
            out_event <= 6'd48;
            st        <= ST_W49;
          end else if (cond_met) begin
            out_event  <= 6'd49;
            out_dir_in <= 1'b0;
            phase_q    <= PH_FWD_IDLE;
            out_done   <= 1'b1;
            st         <= ST_IDLE;
          end else if (wait_hit) begin
            phase_q  <= PH_UNKNOWN;
            err_q    <= ER_LINK;
            out_done <= 1'b1;
            st       <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign out_phase    = phase_q;
  assign out_err      = err_q;
  assign out_rd_avail = !syn.preq;

endmodule

// File: rtl/ecp_phase_seq_chk.sv
module ecp_phase_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] out_phase,
  input logic [1:0] out_err,
  input logic [5:0] out_event,
  input logic       out_done,
  input logic       out_hack,
  input logic       out_rreq,
  input logic       out_dir_in,
  input logic       hold_hit,
  input logic       rej_pulse
);
  // R5: a refused command leaves phase and lines alone and reports a link error
  a_r5_reject_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    rej_pulse |=> (out_done && out_err == 2'd2 && $stable(out_phase) &&
                   $stable(out_hack) && $stable(out_rreq) && $stable(out_dir_in)));

  // R6: the bus is already an input when event 38 is first shown
  a_r6_dir_first: assert property (@(posedge clk) disable iff (!rst_n)
    (out_event == 6'd38 && $past(out_event) != 6'd38) |-> $past(out_dir_in));

  // R7: the reverse request only falls when the hold interval has run out
  a_r7_hold_span: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_rreq) |-> $past(hold_hit));

  // R8: reverse idle always shows the turned-around line state
  a_r8_rev_idle_lines: assert property (@(posedge clk) disable iff (!rst_n)
    (out_phase == 3'd4) |-> (out_dir_in && !out_rreq && !out_hack));

  // R10: forward idle always has the bus driven by the host
  a_r10_fwd_dir_out: assert property (@(posedge clk) disable iff (!rst_n)
    (out_phase == 3'd2) |-> !out_dir_in);

  // R12: done is a single-cycle pulse unless a refusal follows at once
  a_r12_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    out_done |=> (!out_done || $past(rej_pulse)));
endmodule

bind ecp_phase_seq ecp_phase_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .out_phase(out_phase), .out_err(out_err),
  .out_event(out_event), .out_done(out_done), .out_hack(out_hack),
  .out_rreq(out_rreq), .out_dir_in(out_dir_in), .hold_hit(hold_hit),
  .rej_pulse(rej_pulse)
);

// File: tb/tb_ecp_phase_seq.sv
module tb_ecp_phase_seq;
  // 250 MHz: 4 ns per cycle. 500 ns hold -> 125 cycles, 200 ns timeout -> 50.
  localparam int HOLD_EXP = (500 + 3) / 4;
  localparam int TO_EXP   = (200 + 3) / 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_setup = 0, cmd_reverse = 0, cmd_forward = 0;
  logic in_pack = 0, in_pclk = 1, in_arev = 1, in_xflag = 1, in_preq = 1;
  logic out_strb, out_hack, out_rreq, out_sel, out_dir_in, out_done, out_rd_avail;
  logic [2:0] out_phase;
  logic [5:0] out_event;
  logic [1:0] out_err;

  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  ecp_phase_seq #(.CLK_HZ(250_000_000), .HOLD_NS(500), .TIMEOUT_NS(200)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_setup(cmd_setup), .cmd_reverse(cmd_reverse),
    .cmd_forward(cmd_forward), .in_pack(in_pack), .in_pclk(in_pclk),
    .in_arev(in_arev), .in_xflag(in_xflag), .in_preq(in_preq),
    .out_strb(out_strb), .out_hack(out_hack), .out_rreq(out_rreq),
    .out_sel(out_sel), .out_dir_in(out_dir_in), .out_phase(out_phase),
    .out_event(out_event), .out_done(out_done), .out_err(out_err),
    .out_rd_avail(out_rd_avail)
  );

  // {pack, pclk, arev, xflag, preq, expect_success}
  localparam logic [5:0] VEC [8] = '{
    6'b011111, 6'b011101, 6'b111110, 6'b001110,
    6'b010110, 6'b011010, 6'b100000, 6'b011101
  };

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic set_stat(logic [4:0] s);
    {in_pack, in_pclk, in_arev, in_xflag, in_preq} = s;
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse(logic [2:0] c);
    {cmd_setup, cmd_reverse, cmd_forward} = c;
    @(negedge clk);
    {cmd_setup, cmd_reverse, cmd_forward} = 3'b000;
  endtask

  task automatic wait_done(int maxc);
    for (int n = 0; n < maxc && !out_done; n++) @(negedge clk);
  endtask

  task automatic reach_rev_idle();
    set_stat(5'b01111);
    pulse(3'b100);
    @(negedge clk);
    pulse(3'b010);
    for (int n = 0; n < 300 && out_event != 6'd39; n++) @(negedge clk);
    in_arev = 1'b0;
    wait_done(20);
    check("R8 reach reverse idle", out_phase, 4);
    @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1 strb", out_strb, 1); check("R1 hack", out_hack, 1);
    check("R1 rreq", out_rreq, 1); check("R1 sel", out_sel, 1);
    check("R1 dir", out_dir_in, 0); check("R1 phase", out_phase, 0);
    check("R1 event", out_event, 0); check("R1 err", out_err, 0);
    check("R1 done", out_done, 0); check("R1 rd_avail", out_rd_avail, 0);

    // R5 reverse refused in unknown phase
    pulse(3'b010);
    check("R5 done", out_done, 1); check("R5 err", out_err, 2);
    check("R5 phase", out_phase, 0); check("R5 hack", out_hack, 1);
    check("R5 rreq", out_rreq, 1); check("R5 dir", out_dir_in, 0);
    @(negedge clk);
    check("R12 done one cycle", out_done, 0);
    check("R12 err held", out_err, 2);
    pulse(3'b001);
    check("R5 forward refused err", out_err, 2);
    check("R5 forward refused phase", out_phase, 0);

    // R2/R3/R4 vector table over the setup wait
    foreach (VEC[i]) begin
      set_stat(VEC[i][5:1]);
      pulse(3'b100);
      check("R12 err cleared", out_err, 0);
      check("R2 phase", out_phase, 1); check("R2 event", out_event, 30);
      check("R2 hack", out_hack, 0); check("R2 rreq", out_rreq, 1);
      check("R2 sel", out_sel, 1); check("R2 strb", out_strb, 1);
      check("R2 dir", out_dir_in, 0);
      if (VEC[i][0]) begin
        @(negedge clk);
        check("R3 done", out_done, 1); check("R3 phase", out_phase, 2);
        check("R3 event", out_event, 31); check("R3 err", out_err, 0);
      end else begin
        repeat (TO_EXP - 1) @(negedge clk);
        check("R4 not yet", out_done, 0); check("R4 still setup", out_phase, 1);
        @(negedge clk);
        check("R4 done", out_done, 1); check("R4 phase", out_phase, 0);
        check("R4 err", out_err, 1);
      end
      @(negedge clk);
    end

    // R13 condition on the last counted cycle wins
    set_stat(5'b01101);
    pulse(3'b100);
    repeat (TO_EXP - 3) @(negedge clk);
    in_xflag = 1'b1;
    repeat (3) @(negedge clk);
    check("R13 last cycle done", out_done, 1);
    check("R13 last cycle err", out_err, 0);
    check("R13 last cycle phase", out_phase, 2);
    set_stat(5'b01101);
    pulse(3'b100);
    repeat (TO_EXP - 2) @(negedge clk);
    in_xflag = 1'b1;
    repeat (2) @(negedge clk);
    check("R13 one late done", out_done, 1);
    check("R13 one late err", out_err, 1);

    // R12 command during a running sequence is ignored
    set_stat(5'b01101);
    pulse(3'b100);
    pulse(3'b010);
    check("R12 busy phase", out_phase, 1);
    check("R12 busy dir", out_dir_in, 0);
    wait_done(TO_EXP + 5);
    check("R12 ignored err", out_err, 1);
    @(negedge clk);

    // R12 priority: setup wins over reverse
    set_stat(5'b01111);
    pulse(3'b110);
    check("R12 priority phase", out_phase, 1);
    check("R12 priority event", out_event, 30);
    @(negedge clk);
    check("R3 after priority", out_phase, 2);

    // R5 forward refused in forward idle
    pulse(3'b001);
    check("R5 fwd in fwd idle err", out_err, 2);
    check("R5 fwd in fwd idle phase", out_phase, 2);
    @(negedge clk);

    // R6/R7 go-reverse timing, R8 timeout
    pulse(3'b010);
    check("R6 phase", out_phase, 3); check("R6 dir", out_dir_in, 1);
    check("R6 event unchanged", out_event, 31);
    @(negedge clk);
    check("R6 event 38", out_event, 38); check("R6 hack", out_hack, 0);
    check("R7 rreq held", out_rreq, 1);
    repeat (HOLD_EXP - 1) @(negedge clk);
    check("R7 rreq at hold-1", out_rreq, 1);
    check("R7 event at hold-1", out_event, 38);
    @(negedge clk);
    check("R7 rreq fell", out_rreq, 0); check("R7 event 39", out_event, 39);
    wait_done(TO_EXP + 5);
    check("R8 timeout err", out_err, 2); check("R8 timeout phase", out_phase, 0);
    check("R8 timeout event", out_event, 39);
    @(negedge clk);

    // R8 success, then R5 reverse refused in reverse idle
    reach_rev_idle();
    check("R8 event 40", out_event, 40); check("R8 err", out_err, 0);
    pulse(3'b010);
    check("R5 rev in rev idle err", out_err, 2);
    check("R5 rev in rev idle rreq", out_rreq, 0);
    check("R5 rev in rev idle phase", out_phase, 4);
    @(negedge clk);

    // R9/R10 go-forward success
    pulse(3'b001);
    check("R9 phase", out_phase, 5); check("R9 hack", out_hack, 1);
    check("R9 rreq still low", out_rreq, 0);
    @(negedge clk);
    check("R9 rreq", out_rreq, 1); check("R9 event", out_event, 47);
    @(negedge clk);
    check("R10 event 48", out_event, 48);
    in_arev = 1'b1;
    wait_done(20);
    check("R10 phase", out_phase, 2); check("R10 dir", out_dir_in, 0);
    check("R10 event 49", out_event, 49); check("R10 err", out_err, 0);
    @(negedge clk);

    // R10 timeout at event 48
    reach_rev_idle();
    set_stat(5'b00011);
    pulse(3'b001);
    wait_done(TO_EXP + 10);
    check("R10 t48 err", out_err, 2); check("R10 t48 phase", out_phase, 0);
    check("R10 t48 event", out_event, 47);
    @(negedge clk);

    // R10 timeout at event 49
    reach_rev_idle();
    pulse(3'b001);
    wait_done(TO_EXP + 10);
    check("R10 t49 err", out_err, 2); check("R10 t49 event", out_event, 48);
    check("R10 t49 phase", out_phase, 0);

    // R11 read-data-available through two flops
    in_preq = 1'b0;
    @(negedge clk);
    check("R11 one edge", out_rd_avail, 0);
    @(negedge clk);
    check("R11 two edges", out_rd_avail, 1);
    in_preq = 1'b1;
    repeat (2) @(negedge clk);
    check("R11 released", out_rd_avail, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule